// File: doc/BRIEF.md
# Inter-Domain Doorbell Register Block

This block is the register front end of a shared-memory device that lets isolated software domains signal each other. A 32-bit register bus with separate read and write strobes reaches a 256-byte window. The window holds an interrupt mask word, an interrupt status word that empties itself when read, and a read-only word that reports the domain's own position number. It also holds a write-only doorbell word.

A write to the doorbell names a destination peer and a vector. The block checks that pair against a small table of peers. The table holds the number of live peers and, for each peer, how many vectors that peer has registered. When the pair is valid, the block emits a one-cycle notify pulse that carries the peer and the vector. When it is not valid, the write is dropped and nothing else happens.

An incoming-event strobe marks the status word with the value 1 whenever message-signalled interrupts are off. Configuration logic outside the block loads the peer table and the peer count through a separate port.

Top module: `dbell_regblk`

## Requirements
- R1: After reset the mask and status words read as zero, and no notify pulse is present.
- R2: A write to word 0 (mask) loads all 32 data bits, and a read of byte address 0x00 returns them. Write decode ignores address bits 1:0, so a write to 0x03 also loads the mask.
- R3: A write to word 1 (status, byte address 0x04) loads all 32 bits. A read of 0x04 returns the current status and leaves the status at zero, so a second read returns 0.
- R4: A read of byte address 0x08 returns the `self_id` input zero-extended to 32 bits. Writes to word 2 change nothing.
- R5: A read returns zero for byte address 0x0C, for any address above 0x0C, and for any address whose bits 1:0 are not zero. Such a read does not clear the status.
- R6: A doorbell write (word 3) takes the peer from data bits 31:16 and the vector from bits 7:0; bits 15:8 are ignored. When the write is accepted, `ntf_valid` is high for exactly the next cycle, with `ntf_peer` and `ntf_vec` set to the decoded values.
- R7: A doorbell write whose peer is greater than or equal to the configured peer count produces no notify.
- R8: A doorbell write whose vector is greater than or equal to the destination peer's vector count produces no notify. A peer with a count of zero accepts no vector.
- R9: A cycle with `evt_in` high and `msi_en` low sets the status to 1. With `msi_en` high the event leaves the status unchanged.
- R10: Same-cycle order on the status word, from highest priority to lowest, is: bus write, then incoming event, then read-clear. A read that meets an event still returns the old value and leaves the status at 1.
- R11: Writes to unmapped word offsets (4 to 63) change neither the mask nor the status.
- R12: `cfg_tbl_we` loads the vector count of the entry selected by `cfg_tbl_idx`, and `cfg_npeer_we` loads the peer count. A peer ID at or above the table depth is always dropped, even when the peer count is larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after `rd_en` |
| self_id | input | 16 | Own position number, reported at 0x08 |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| evt_in | input | 1 | Incoming event strobe |
| cfg_tbl_we | input | 1 | Load one peer-table entry |
| cfg_tbl_idx | input | IDX_W | Entry to load |
| cfg_tbl_vcnt | input | 8 | Vector count for that entry |
| cfg_npeer_we | input | 1 | Load the peer count |
| cfg_npeer | input | 16 | Peer count value |
| ntf_valid | output | 1 | One-cycle notify pulse |
| ntf_peer | output | 16 | Peer ID of the notify |
| ntf_vec | output | 8 | Vector of the notify |

## Verification
Doorbell rings are tried in four groups:
- Accepted pairs, with nonzero filler in bits 15:8. These show that the filler bits do not reach the decoded fields.
- Peers just at the peer count and beyond it. These separate the peer-count test from the vector test.
- Vectors equal to the peer's count, vectors against a zero-count peer, and vector 0xFF. These find an off-by-one in the vector comparison.
- Peers beyond the table depth while the peer count is larger. These show that the table bound applies by itself.

Status traffic is driven as lone writes, reads and events, and also as same-cycle pairs. The pairs expose the order between write, event and read-clear.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PEER_W = 16;
    localparam int VEC_W  = 8;

    // word indices (address bits 7:2)
    localparam logic [5:0] W_MASK = 6'd0;
    localparam logic [5:0] W_STAT = 6'd1;
    localparam logic [5:0] W_SELF = 6'd2;
    localparam logic [5:0] W_RING = 6'd3;

    typedef struct packed {
        logic [PEER_W-1:0] peer;
        logic [VEC_W-1:0]  vec;
    } ring_t;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] rdata;
        logic              ntf_valid;
        ring_t             ntf;
    } regs_t;

endpackage

// File: rtl/dbell_peer_tbl.sv
module dbell_peer_tbl
    import dbell_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tbl_we,
    input  logic [IDX_W-1:0]  cfg_tbl_idx,
    input  logic [VEC_W-1:0]  cfg_tbl_vcnt,
    input  logic              cfg_npeer_we,
    input  logic [PEER_W-1:0] cfg_npeer,
    input  logic [PEER_W-1:0] lkp_peer,
    output logic [VEC_W-1:0]  lkp_vcnt,
    output logic [PEER_W-1:0] npeer_q
);

    localparam logic [PEER_W-1:0] DEPTH_P = PEER_W'(DEPTH);

    logic [VEC_W-1:0]  ent [DEPTH];
    logic [PEER_W-1:0] npeer_d;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [VEC_W-1:0] vc_d, vc_q;

        always_comb begin
            vc_d = vc_q;
            if (cfg_tbl_we && cfg_tbl_idx == IDX_W'(i)) begin
                vc_d = cfg_tbl_vcnt;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vc_q <= '0;
            else        vc_q <= vc_d;
        end

        assign ent[i] = vc_q;
    end

    always_comb begin
        npeer_d = cfg_npeer_we ? cfg_npeer : npeer_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) npeer_q <= '0;
        else        npeer_q <= npeer_d;
    end

    // peers outside the table have no vectors
    always_comb begin
        lkp_vcnt = '0;
        if (lkp_peer < DEPTH_P) begin
            lkp_vcnt = ent[lkp_peer[IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/dbell_ring_chk.sv
module dbell_ring_chk
    import dbell_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic [PEER_W-1:0] npeer,
    input  logic [VEC_W-1:0]  vcnt,
    output logic [PEER_W-1:0] peer,
    output ring_t             ring,
    output logic              ok
);

    logic unused_mid;

    assign peer       = wdata[31:16];
    assign unused_mid = ^wdata[15:8];

    always_comb begin
        ring.peer = wdata[31:16];
        ring.vec  = wdata[7:0];
        ok        = (ring.peer < npeer) && (ring.vec < vcnt);
    end

endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
    import dbell_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [PEER_W-1:0] self_id,
    input  logic              msi_en,
    input  logic              evt_in,
    input  logic              cfg_tbl_we,
    input  logic [IDX_W-1:0]  cfg_tbl_idx,
    input  logic [VEC_W-1:0]  cfg_tbl_vcnt,
    input  logic              cfg_npeer_we,
    input  logic [PEER_W-1:0] cfg_npeer,
    output logic              ntf_valid,
    output logic [PEER_W-1:0] ntf_peer,
    output logic [VEC_W-1:0]  ntf_vec
);

    regs_t             q, d;
    logic [PEER_W-1:0] lkp_peer;
    logic [VEC_W-1:0]  lkp_vcnt;
    logic [PEER_W-1:0] npeer_cur;
    ring_t             ring;
    logic              ring_ok;
    logic [5:0]        wr_word;
    logic [5:0]        rd_word;
    logic              rd_aligned;
    logic [DATA_W-1:0] mask_cur;
    logic [DATA_W-1:0] stat_cur;

    dbell_peer_tbl #(.DEPTH(DEPTH)) u_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_tbl_we   (cfg_tbl_we),
        .cfg_tbl_idx  (cfg_tbl_idx),
        .cfg_tbl_vcnt (cfg_tbl_vcnt),
        .cfg_npeer_we (cfg_npeer_we),
        .cfg_npeer    (cfg_npeer),
        .lkp_peer     (lkp_peer),
        .lkp_vcnt     (lkp_vcnt),
        .npeer_q      (npeer_cur)
    );

    dbell_ring_chk u_chk (
        .wdata (wdata),
        .npeer (npeer_cur),
        .vcnt  (lkp_vcnt),
        .peer  (lkp_peer),
        .ring  (ring),
        .ok    (ring_ok)
    );

    assign wr_word    = addr[7:2];
    assign rd_word    = addr[7:2];
    assign rd_aligned = (addr[1:0] == 2'b00);

    always_comb begin
        d           = q;
        d.ntf_valid = 1'b0;

        // read path: result registered, status cleared by its read
        if (rd_en) begin
            d.rdata = '0;
            if (rd_aligned) begin
                unique case (rd_word)
                    W_MASK: d.rdata = q.mask;
                    W_STAT: begin
                        d.rdata = q.stat;
                        d.stat  = '0;
                    end
                    W_SELF: d.rdata = {{(DATA_W-PEER_W){1'b0}}, self_id};
                    default: d.rdata = '0;
                endcase
            end
        end

        // incoming event outranks read-clear
        if (evt_in && !msi_en) begin
            d.stat = 32'd1;
        end

        // bus writes outrank everything
        if (wr_en) begin
            unique case (wr_word)
                W_MASK: d.mask = wdata;
                W_STAT: d.stat = wdata;
                W_RING: begin
                    if (ring_ok) begin
                        d.ntf_valid = 1'b1;
                        d.ntf       = ring;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata     = q.rdata;
    assign ntf_valid = q.ntf_valid;
    assign ntf_peer  = q.ntf.peer;
    assign ntf_vec   = q.ntf.vec;
    assign mask_cur  = q.mask;
    assign stat_cur  = q.stat;

endmodule

module dbell_regblk_chk
    import dbell_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              msi_en,
    input logic              evt_in,
    input logic              ntf_valid,
    input logic [PEER_W-1:0] ntf_peer,
    input logic [VEC_W-1:0]  ntf_vec,
    input logic [PEER_W-1:0] npeer_cur,
    input logic [VEC_W-1:0]  lkp_vcnt,
    input logic [DATA_W-1:0] mask_cur,
    input logic [DATA_W-1:0] stat_cur
);

    // R6
    ntf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> ($past(wr_en) && $past(addr[7:2]) == W_RING
                       && ntf_peer == $past(wdata[31:16])
                       && ntf_vec == $past(wdata[7:0])));

    // R7
    drop_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[7:2] == W_RING && wdata[31:16] >= npeer_cur) |=> !ntf_valid);

    // R8
    drop_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[7:2] == W_RING && wdata[7:0] >= lkp_vcnt) |=> !ntf_valid);

    // R3
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h04 && !wr_en && !(evt_in && !msi_en))
        |=> (stat_cur == '0 && rdata == $past(stat_cur)));

    // R9
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in && !msi_en && !(wr_en && addr[7:2] == W_STAT)) |=> stat_cur == 32'd1);

    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[7:2] == W_MASK) |=> mask_cur == $past(wdata));

endmodule

bind dbell_regblk dbell_regblk_chk u_regblk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .msi_en    (msi_en),
    .evt_in    (evt_in),
    .ntf_valid (ntf_valid),
    .ntf_peer  (ntf_peer),
    .ntf_vec   (ntf_vec),
    .npeer_cur (npeer_cur),
    .lkp_vcnt  (lkp_vcnt),
    .mask_cur  (mask_cur),
    .stat_cur  (stat_cur)
);

// File: tb/tb_dbell_regblk.sv
module tb_dbell_regblk;
    import dbell_pkg::*;

    localparam int DEPTH = 16;
    localparam int IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [15:0]       self_id = 16'h002B;
    logic              msi_en = 1'b0;
    logic              evt_in = 1'b0;
    logic              cfg_tbl_we = 1'b0;
    logic [IDX_W-1:0]  cfg_tbl_idx = '0;
    logic [7:0]        cfg_tbl_vcnt = '0;
    logic              cfg_npeer_we = 1'b0;
    logic [15:0]       cfg_npeer = '0;
    logic              ntf_valid;
    logic [15:0]       ntf_peer;
    logic [7:0]        ntf_vec;

    int    n_chk = 0;
    int    n_bad = 0;
    ring_t exp_q[$];

    always #10 clk = ~clk;

    dbell_regblk #(.DEPTH(DEPTH)) dut (.*);

    task automatic chk(input logic cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                       input logic [31:0] dat, input logic ev, output logic [31:0] res);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = dat; evt_in = ev;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt_in = 1'b0;
        res = rdata;
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] dat);
        logic [31:0] unused_r;
        cyc(1'b1, 1'b0, a, dat, 1'b0, unused_r);
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] res);
        cyc(1'b0, 1'b1, a, '0, 1'b0, res);
    endtask

    task automatic set_ent(input int idx, input logic [7:0] v);
        @(negedge clk);
        cfg_tbl_we = 1'b1; cfg_tbl_idx = IDX_W'(idx); cfg_tbl_vcnt = v;
        @(negedge clk);
        cfg_tbl_we = 1'b0;
    endtask

    task automatic set_npeer(input logic [15:0] n);
        @(negedge clk);
        cfg_npeer_we = 1'b1; cfg_npeer = n;
        @(negedge clk);
        cfg_npeer_we = 1'b0;
    endtask

    // driver: pushes expected notify when the ring should be accepted
    task automatic ring(input logic [15:0] p, input logic [7:0] v, input logic [7:0] mid,
                        input logic accept, input string tag);
        ring_t e;
        e.peer = p;
        e.vec  = v;
        if (accept) exp_q.push_back(e);
        bwr(8'h0C, {p, mid, v});
        if (!accept) chk(ntf_valid == 1'b0, tag, {31'd0, ntf_valid}, 32'd0);
    endtask

    // monitor: pops and compares every notify pulse
    always @(negedge clk) begin
        if (rst_n && ntf_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected notify", {ntf_peer, 8'h00, ntf_vec}, 32'd0);
            end else begin
                ring_t e;
                e = exp_q.pop_front();
                chk(ntf_peer == e.peer && ntf_vec == e.vec, "R6 notify content",
                    {ntf_peer, 8'h00, ntf_vec}, {e.peer, 8'h00, e.vec});
            end
        end
    end

    initial begin
        #4000000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        chk(ntf_valid == 1'b0, "R1 notify idle in reset", {31'd0, ntf_valid}, 32'd0);
        rst_n = 1'b1;

        // R1
        brd(8'h00, r); chk(r == 32'd0, "R1 mask reset", r, 32'd0);
        brd(8'h04, r); chk(r == 32'd0, "R1 status reset", r, 32'd0);

        // R2
        bwr(8'h00, 32'hA5A5_5A5A);
        brd(8'h00, r); chk(r == 32'hA5A5_5A5A, "R2 mask write", r, 32'hA5A5_5A5A);
        bwr(8'h03, 32'h1234_5678);
        brd(8'h00, r); chk(r == 32'h1234_5678, "R2 mask via 0x03", r, 32'h1234_5678);

        // R3
        bwr(8'h04, 32'hDEAD_BEEF);
        brd(8'h04, r); chk(r == 32'hDEAD_BEEF, "R3 status read", r, 32'hDEAD_BEEF);
        brd(8'h04, r); chk(r == 32'd0, "R3 status cleared", r, 32'd0);

        // R4
        brd(8'h08, r); chk(r == 32'h0000_002B, "R4 self id", r, 32'h2B);
        bwr(8'h08, 32'hFFFF_FFFF);
        brd(8'h08, r); chk(r == 32'h0000_002B, "R4 self id write ignored", r, 32'h2B);

        // R5
        bwr(8'h04, 32'h0000_0077);
        brd(8'h0C, r); chk(r == 32'd0, "R5 doorbell reads zero", r, 32'd0);
        brd(8'h40, r); chk(r == 32'd0, "R5 unmapped reads zero", r, 32'd0);
        brd(8'h05, r); chk(r == 32'd0, "R5 unaligned read zero", r, 32'd0);
        brd(8'h04, r); chk(r == 32'h77, "R5 status kept after unaligned read", r, 32'h77);

        // R11
        bwr(8'h20, 32'hCAFE_F00D);
        bwr(8'hFC, 32'hCAFE_F00D);
        brd(8'h00, r); chk(r == 32'h1234_5678, "R11 mask unchanged", r, 32'h1234_5678);
        brd(8'h04, r); chk(r == 32'd0, "R11 status unchanged", r, 32'd0);

        // R12 configuration
        set_npeer(16'd4);
        set_ent(0, 8'd2);
        set_ent(1, 8'd1);
        set_ent(2, 8'd0);
        set_ent(3, 8'd8);
        set_ent(5, 8'd3);

        // R6
        ring(16'd0, 8'd1, 8'hFF, 1'b1, "R6 accept 0/1");
        ring(16'd3, 8'd7, 8'h5A, 1'b1, "R6 accept 3/7");
        ring(16'd1, 8'd0, 8'h00, 1'b1, "R6 accept 1/0");
        // R7
        ring(16'd4, 8'd0, 8'h00, 1'b0, "R7 peer at count dropped");
        ring(16'd5, 8'd0, 8'h00, 1'b0, "R7 peer above count dropped");
        ring(16'hFFFF, 8'd0, 8'h00, 1'b0, "R7 peer max dropped");
        // R8
        ring(16'd0, 8'd2, 8'h00, 1'b0, "R8 vector at count dropped");
        ring(16'd2, 8'd0, 8'h00, 1'b0, "R8 zero-count peer dropped");
        ring(16'd3, 8'hFF, 8'h00, 1'b0, "R8 vector 0xFF dropped");
        // R12
        set_npeer(16'd20);
        ring(16'd5, 8'd2, 8'h11, 1'b1, "R12 entry 5 now live");
        ring(16'd17, 8'd0, 8'h00, 1'b0, "R12 beyond depth dropped");

        // R9
        msi_en = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, '0, 1'b1, r);
        brd(8'h04, r); chk(r == 32'd0, "R9 event ignored with msi", r, 32'd0);
        msi_en = 1'b0;
        cyc(1'b0, 1'b0, 8'h00, '0, 1'b1, r);
        brd(8'h04, r); chk(r == 32'd1, "R9 event sets status", r, 32'd1);

        // R10
        cyc(1'b1, 1'b0, 8'h04, 32'h55, 1'b1, r);
        brd(8'h04, r); chk(r == 32'h55, "R10 write beats event", r, 32'h55);
        bwr(8'h04, 32'h33);
        cyc(1'b0, 1'b1, 8'h04, '0, 1'b1, r);
        chk(r == 32'h33, "R10 read returns old value", r, 32'h33);
        brd(8'h04, r); chk(r == 32'd1, "R10 event beats read clear", r, 32'd1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all notifies seen", exp_q.size(), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule